// File: doc/BRIEF.md
# Hybrid Carry-Select Prefix Adder

This block adds two 64-bit operands and a carry-in in one combinational pass, giving a 64-bit sum and a carry-out. The operands are cut into eight 8-bit slices. Every slice computes two candidate results side by side: one that assumes no carry enters the slice and one that assumes a carry does. The carry that actually enters each slice then picks the correct candidate.

The slice carries do not ripple from one slice to the next. A three-level tree of radix-4 propagate/generate merge cells computes them. Each merge cell takes four (propagate, generate) pairs and returns three running pairs. Its input ranges may overlap, so the tree can reuse partial spans. The external carry-in is folded into the lowest bit's generate term. Because of this, the carry into every slice is the generate term of the span that runs from bit 0 up to that slice's boundary.

The block is meant to sit in a datapath as a drop-in adder. It has no clock and no state.

Top module: `hybrid_csel_adder`

## Requirements
- R1: For any operands and carry-in, {cout, sum} equals opa + opb + cin as a 65-bit unsigned value.
- R2: cout is 1 exactly when the true 65-bit total is 2^64 or more.
- R3: With both operands zero, sum equals cin (0 or 1 in bit 0) and cout is 0.
- R4: When opa ^ opb is all ones, a carry-in of 1 travels through all 64 bits: sum is zero and cout is 1. With cin = 0, sum is all ones and cout is 0.
- R5: A carry crosses every 8-bit slice boundary correctly. With opa = 2^(8k) - 1, opb = 0 and cin = 1, the sum is exactly 2^(8k) for k = 1 to 7, and cout is 0.
- R6: The carry used by slice i (i ≥ 1) equals the carry out of bits 8i-1:0 of opa + opb + cin. Slice 0 uses cin.
- R7: When opa & opb is zero and cin is 0, no carry is formed anywhere: sum equals opa | opb and cout is 0.
- R8: All-ones plus all-ones plus a carry-in of 1 gives sum all ones and cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Low 64 bits of the total |
| cout | output | 1 | Carry out of bit 63 |

## Verification
Patterns where the operands are bitwise complements of each other make a carry-in travel through every merge cell and every slice select. This shows that the lowest span really absorbs the carry-in and that the overlapping third-level spans join correctly. Operands that end in a run of ones stopping at each 8-bit boundary make exactly one slice carry toggle, so a miswired tree output shows up in one slice. Operands with disjoint bits, all-ones operands and random vectors then separate the "no generate anywhere" case from the "generate everywhere" case and cover mixed carry shapes across all eight slices.

// File: rtl/hca_pkg.sv
package hca_pkg;

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    localparam pg_t PG_IDENT = '{p: 1'b1, g: 1'b0};

    // Combine a higher span with the span directly (or overlapping) below it.
    function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
        pg_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/hca_merge4.sv
module hca_merge4
    import hca_pkg::*;
(
    input  pg_t [3:0] in_pg,   // [0] is the lowest span
    output pg_t [2:0] run_pg   // [n] spans in_pg[0] up to in_pg[n+1]
);
    pg_t step1, step2, step3;

    always_comb begin
        step1  = pg_merge(in_pg[1], in_pg[0]);
        step2  = pg_merge(in_pg[2], step1);
        step3  = pg_merge(in_pg[3], step2);
        run_pg = {step3, step2, step1};
    end
endmodule

// File: rtl/hca_cond_group.sv
module hca_cond_group #(
    parameter int GW = 8
) (
    input  logic [GW-1:0] ga,
    input  logic [GW-1:0] gb,
    input  logic          sel_c,
    output logic [GW-1:0] gsum,
    output logic          gcout
);
    logic [GW:0]   k0_d, k1_d;
    logic [GW-1:0] s0_d, s1_d;

    always_comb begin
        k0_d[0] = 1'b0;
        k1_d[0] = 1'b1;
        for (int i = 0; i < GW; i++) begin
            s0_d[i]   = ga[i] ^ gb[i] ^ k0_d[i];
            s1_d[i]   = ga[i] ^ gb[i] ^ k1_d[i];
            k0_d[i+1] = (ga[i] & gb[i]) | ((ga[i] ^ gb[i]) & k0_d[i]);
            k1_d[i+1] = (ga[i] & gb[i]) | ((ga[i] ^ gb[i]) & k1_d[i]);
        end
        gsum  = sel_c ? s1_d : s0_d;
        gcout = sel_c ? k1_d[GW] : k0_d[GW];
    end
endmodule

// File: rtl/hca_carry_tree.sv
module hca_carry_tree
    import hca_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int GW    = 8
) (
    input  logic [WIDTH-1:0]    ta,
    input  logic [WIDTH-1:0]    tb,
    input  logic                tcin,
    output logic [WIDTH/GW-1:0] grp_c
);
    localparam int NGRP  = WIDTH / GW;
    localparam int NBLK1 = (WIDTH - GW) / 4;     // 4-bit spans below the top slice
    localparam int NPAD1 = ((NBLK1 + 3) / 4) * 4;
    localparam int NCEL2 = NPAD1 / 4;

    pg_t [WIDTH-GW-1:0] bit_pg;
    pg_t [NPAD1-1:0]    lvl1;
    pg_t [2:0]          lvl2 [NCEL2];
    pg_t [2:0]          lvl3_lo, lvl3_hi;

    genvar gi;

    // Bit level, carry-in folded into bit 0
    generate
        for (gi = 0; gi < WIDTH - GW; gi++) begin : g_bit
            if (gi == 0) begin : g_b0
                assign bit_pg[gi].p = ta[gi] ^ tb[gi];
                assign bit_pg[gi].g = (ta[gi] & tb[gi]) | ((ta[gi] ^ tb[gi]) & tcin);
            end else begin : g_bn
                assign bit_pg[gi].p = ta[gi] ^ tb[gi];
                assign bit_pg[gi].g = ta[gi] & tb[gi];
            end
        end
    endgenerate

    // Level 1: 4-bit spans, only the full-span output kept
    generate
        for (gi = 0; gi < NPAD1; gi++) begin : g_l1
            if (gi < NBLK1) begin : g_cell
                pg_t [2:0] run;
                hca_merge4 u_m (.in_pg(bit_pg[4*gi+3 -: 4]), .run_pg(run));
                assign lvl1[gi] = run[2];
            end else begin : g_pad
                assign lvl1[gi] = PG_IDENT;
            end
        end
    endgenerate

    // Level 2: spans 7:0/15:0, 23:16/31:16, 39:32/47:32, 55:48
    generate
        for (gi = 0; gi < NCEL2; gi++) begin : g_l2
            hca_merge4 u_m (.in_pg(lvl1[4*gi+3 -: 4]), .run_pg(lvl2[gi]));
        end
    endgenerate

    // Level 3: overlapping spans feed two cells
    hca_merge4 u_l3_lo (
        .in_pg ({lvl2[2][0], lvl2[1][2], lvl2[1][0], lvl2[0][2]}),
        .run_pg(lvl3_lo)
    );
    hca_merge4 u_l3_hi (
        .in_pg ({lvl2[3][0], lvl2[2][2], lvl2[1][2], lvl2[0][2]}),
        .run_pg(lvl3_hi)
    );

    always_comb begin
        grp_c    = '0;
        grp_c[0] = tcin;
        grp_c[1] = lvl2[0][0].g;     // into bit 8
        grp_c[2] = lvl2[0][2].g;     // into bit 16
        grp_c[3] = lvl3_lo[0].g;     // into bit 24
        grp_c[4] = lvl3_lo[1].g;     // into bit 32
        grp_c[5] = lvl3_lo[2].g;     // into bit 40
        grp_c[6] = lvl3_hi[1].g;     // into bit 48
        grp_c[NGRP-1] = lvl3_hi[2].g; // into bit 56
    end
endmodule

// File: rtl/hybrid_csel_adder.sv
module hybrid_csel_adder #(
    parameter int WIDTH = 64,
    parameter int GW    = 8
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NGRP = WIDTH / GW;

    logic [NGRP-1:0] grp_cin;
    logic [NGRP-1:0] grp_cout;

    hca_carry_tree #(.WIDTH(WIDTH), .GW(GW)) u_tree (
        .ta   (opa),
        .tb   (opb),
        .tcin (cin),
        .grp_c(grp_cin)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NGRP; gi++) begin : g_slice
            hca_cond_group #(.GW(GW)) u_grp (
                .ga   (opa[gi*GW +: GW]),
                .gb   (opb[gi*GW +: GW]),
                .sel_c(grp_cin[gi]),
                .gsum (sum[gi*GW +: GW]),
                .gcout(grp_cout[gi])
            );
        end
    endgenerate

    assign cout = grp_cout[NGRP-1];
endmodule

// File: rtl/hca_adder_chk.sv
module hca_adder_chk #(
    parameter int WIDTH = 64,
    parameter int GW    = 8
) (
    input logic [WIDTH-1:0]    opa,
    input logic [WIDTH-1:0]    opb,
    input logic                cin,
    input logic [WIDTH-1:0]    sum,
    input logic                cout,
    input logic [WIDTH/GW-1:0] grp_cin
);
    localparam int NGRP = WIDTH / GW;

    logic [WIDTH:0] total;
    logic [WIDTH:0] low_part;
    logic [WIDTH:0] mask;
    logic           known;

    always_comb begin
        known = !$isunknown({opa, opb, cin, sum, cout, grp_cin});
        total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
        if (known) begin
            AST_SUM_EXACT: assert ({cout, sum} == total)
                else $error("sum mismatch"); // R1
            AST_COUT_RANGE: assert (cout == total[WIDTH])
                else $error("carry-out mismatch"); // R2
            if ((opa ^ opb) == '1) begin
                AST_LONG_CHAIN: assert (cout == cin && sum == {WIDTH{~cin}})
                    else $error("propagate chain broken"); // R4
            end
            if ((opa & opb) == '0 && !cin) begin
                AST_NO_GENERATE: assert (cout == 1'b0 && sum == (opa | opb))
                    else $error("spurious carry"); // R7
            end
            AST_SLICE0_CIN: assert (grp_cin[0] == cin)
                else $error("slice 0 carry"); // R6
            for (int i = 1; i < NGRP; i++) begin
                mask     = ({{WIDTH{1'b0}}, 1'b1} << (i * GW)) - 1'b1;
                low_part = ({1'b0, opa} & mask) + ({1'b0, opb} & mask)
                         + {{WIDTH{1'b0}}, cin};
                AST_SLICE_CARRY: assert (grp_cin[i] == low_part[i*GW])
                    else $error("slice carry %0d wrong", i); // R6
            end
        end
    end
endmodule

bind hybrid_csel_adder hca_adder_chk #(.WIDTH(WIDTH), .GW(GW)) u_chk (
    .opa    (opa),
    .opb    (opb),
    .cin    (cin),
    .sum    (sum),
    .cout   (cout),
    .grp_cin(grp_cin)
);

// File: tb/tb_hybrid_csel_adder.sv
module tb_hybrid_csel_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        cin = 1'b0;
    logic [63:0] sum;
    logic        cout;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    hybrid_csel_adder dut (
        .opa (opa),
        .opb (opb),
        .cin (cin),
        .sum (sum),
        .cout(cout)
    );

    // {opa, opb, cin}
    localparam logic [128:0] TBL [0:11] = '{
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0},
        {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b0},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b1},
        {64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1},
        {64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0},
        {64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b1},
        {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0},
        {64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0},
        {64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b1},
        {64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b1},
        {64'hF0F0_F0F0_0F0F_0F0F, 64'h0F0F_0F0F_F0F0_F0F0, 1'b0}
    };

    task automatic apply(input logic [63:0] va, input logic [63:0] vb,
                         input logic vc, input string tag);
        logic [64:0] exp;
        @(posedge clk);
        opa = va;
        opb = vb;
        cin = vc;
        @(negedge clk);
        exp = {1'b0, va} + {1'b0, vb} + {64'd0, vc};
        total++;
        if ({cout, sum} !== exp) begin
            bad++;
            $display("FAIL %s: a=%h b=%h cin=%0d got %h_%h exp %h_%h",
                     tag, va, vb, vc, cout, sum, exp[64], exp[63:0]);
        end
    endtask

    task automatic expect_val(input logic [63:0] es, input logic ec, input string tag);
        total++;
        if (sum !== es || cout !== ec) begin
            bad++;
            $display("FAIL %s: got %h/%0d exp %h/%0d", tag, sum, cout, es, ec);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_val(64'd0, 1'b0, "R3 idle zero");

        for (int i = 0; i < 12; i++)
            apply(TBL[i][128:65], TBL[i][64:1], TBL[i][0], "R1 table");

        apply(64'd0, 64'd0, 1'b1, "R3 cin only");
        expect_val(64'd1, 1'b0, "R3 cin lands in bit0");

        apply(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, "R4 chain");
        expect_val(64'd0, 1'b1, "R4 chain wraps");
        apply(64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF, 1'b0, "R4 chain cin0");
        expect_val(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R4 no wrap");

        for (int k = 1; k < 8; k++) begin
            apply((64'd1 << (8 * k)) - 64'd1, 64'd0, 1'b1, "R5 boundary");
            expect_val(64'd1 << (8 * k), 1'b0, "R5 boundary exact");
            apply(64'd1 << (8 * k - 1), 64'd1 << (8 * k - 1), 1'b0, "R6 slice carry");
        end

        apply(64'hF0F0_1234_0000_8001, 64'h0F0F_0000_FFFF_0000, 1'b0, "R7 disjoint");
        expect_val(64'hFFFF_1234_FFFF_8001, 1'b0, "R7 or result");

        apply('1, '1, 1'b1, "R8 max");
        expect_val('1, 1'b1, "R8 max result");
        apply('1, 64'd1, 1'b0, "R2 overflow");
        expect_val(64'd0, 1'b1, "R2 carry out");

        for (int n = 0; n < 3000; n++)
            apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule